// File: doc/BRIEF.md
# Lock-Bit Memory Protection Controller

This block keeps three sticky lock bits for an on-chip program memory and turns them into grant or deny decisions for four kinds of access: code-byte table lookups issued while running from external program memory, memory programming, verify reads, and instruction fetch from external memory. Each further programmed bit adds a restriction on top of the ones before it, so the protection grows in steps. A programmed bit is cleared only by a chip erase, or by a power-on reset that models a fresh device.

Once any lock bit is programmed, the external-access pin level matters. The block samples that pin on every clock while the ordinary reset is held and keeps the last sample once reset is released. After reset, a difference between the kept sample and the live pin raises a fault flag. While that flag is up, fetch grants are withheld.

Top module: `lock_guard`

## Requirements
- R1: Power-on reset (`por_n` low, asynchronous) clears all three lock bits, so `lock_bits` reads 3'b000 at once and stays there while `por_n` is low.
- R2: A high `prog_lb[i]` at a rising edge sets `lock_bits[i]` (bit 0 is the first lock, bit 1 the second, bit 2 the third). A set bit stays set at every later edge that has no erase.
- R3: A high `chip_erase` at a rising edge clears all lock bits, even when program strobes are high in the same cycle.
- R4: With `lock_bits` equal to 3'b000, every grant output equals its request input in the same cycle.
- R5: With any lock bit set, `grant_movc` and `grant_prog` are 0.
- R6: With `lock_bits[1]` or `lock_bits[2]` set, `grant_verify` is 0. Otherwise it equals `req_verify`.
- R7: With `lock_bits[2]` set, `grant_ext` is 0. Otherwise it equals `req_ext_fetch` unless R9 forces it low.
- R8: While `rst_n` is low, the EA latch takes `ea_pin` at each rising edge. While `rst_n` is high, the latch holds its value.
- R9: `ea_mismatch` is 1 exactly when `rst_n` is high, at least one lock bit is set, and the latch differs from `ea_pin`. While it is 1, `grant_ext` and `grant_movc` are 0.
- R10: Power-on reset clears the EA latch to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears lock bits and EA latch |
| rst_n | input | 1 | Ordinary reset, active low; EA is sampled while it is low |
| prog_lb | input | 3 | Per-bit lock program strobes |
| chip_erase | input | 1 | Chip erase strobe; clears all lock bits |
| ea_pin | input | 1 | Live external-access pin level |
| req_movc | input | 1 | Code-byte lookup from external program memory |
| req_prog | input | 1 | Memory program request |
| req_verify | input | 1 | Verify read request |
| req_ext_fetch | input | 1 | External program fetch request |
| grant_movc | output | 1 | Lookup granted |
| grant_prog | output | 1 | Programming granted |
| grant_verify | output | 1 | Verify granted |
| grant_ext | output | 1 | External fetch granted |
| ea_mismatch | output | 1 | Latched EA differs from live pin while locked |
| lock_bits | output | 3 | Current lock bit state |

## Verification
The hardest state to reach is a mismatch fault. It needs a lock bit that is already programmed, a reset pulse that captures one EA level, and then a change of the pin after reset is released. The random stimulus pulses `rst_n` and toggles `ea_pin` independently, so the pin often changes outside reset. Erase stays rare, so lock bits persist across those reset pulses. Directed steps first build that sequence on purpose and check the masking of fetch grants.

// File: rtl/lock_guard.sv
module lock_guard #(
  parameter int NUM_LOCKS = 3
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 rst_n,
  input  logic [NUM_LOCKS-1:0] prog_lb,
  input  logic                 chip_erase,
  input  logic                 ea_pin,
  input  logic                 req_movc,
  input  logic                 req_prog,
  input  logic                 req_verify,
  input  logic                 req_ext_fetch,
  output logic                 grant_movc,
  output logic                 grant_prog,
  output logic                 grant_verify,
  output logic                 grant_ext,
  output logic                 ea_mismatch,
  output logic [NUM_LOCKS-1:0] lock_bits
);

  localparam int LW = $clog2(NUM_LOCKS + 1);

  logic [NUM_LOCKS-1:0] lb_q;
  logic                 ea_q;
  logic [LW-1:0]        level;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lb_q <= '0;
      ea_q <= 1'b0;
    end else begin
      if (chip_erase) lb_q <= '0;
      else            lb_q <= lb_q | prog_lb;
      if (!rst_n) ea_q <= ea_pin;
    end
  end

  always_comb begin
    level = '0;
    for (int i = 0; i < NUM_LOCKS; i++)
      if (lb_q[i]) level = LW'(i + 1);
  end

  assign lock_bits    = lb_q;
  assign ea_mismatch  = rst_n && (level != '0) && (ea_q != ea_pin);
  assign grant_movc   = req_movc && (level == '0) && !ea_mismatch;
  assign grant_prog   = req_prog && (level == '0);
  assign grant_verify = req_verify && (level < LW'(2));
  assign grant_ext    = req_ext_fetch && (level < LW'(3)) && !ea_mismatch;

endmodule

// File: rtl/lock_guard_chk.sv
module lock_guard_chk (
  input logic       clk,
  input logic       por_n,
  input logic       chip_erase,
  input logic [2:0] prog_lb,
  input logic [2:0] lock_bits,
  input logic       grant_movc,
  input logic       grant_prog,
  input logic       grant_verify,
  input logic       grant_ext,
  input logic       ea_mismatch
);
  // R2
  sticky_bits_chk: assert property (@(posedge clk) disable iff (!por_n)
    !chip_erase |=> ((lock_bits & $past(lock_bits)) == $past(lock_bits)));
  // R2
  prog_sets_chk: assert property (@(posedge clk) disable iff (!por_n)
    !chip_erase |=> ((lock_bits & $past(prog_lb)) == $past(prog_lb)));
  // R3
  erase_clears_chk: assert property (@(posedge clk) disable iff (!por_n)
    chip_erase |=> (lock_bits == 3'b000));
  // R5
  prog_denied_chk: assert property (@(posedge clk) disable iff (!por_n)
    (lock_bits != 3'b000) |-> !grant_prog && !grant_movc);
  // R6
  verify_denied_chk: assert property (@(posedge clk) disable iff (!por_n)
    (lock_bits[2] || lock_bits[1]) |-> !grant_verify);
  // R7
  ext_denied_chk: assert property (@(posedge clk) disable iff (!por_n)
    lock_bits[2] |-> !grant_ext);
  // R9
  mismatch_mask_chk: assert property (@(posedge clk) disable iff (!por_n)
    ea_mismatch |-> !grant_ext && !grant_movc && (lock_bits != 3'b000));
endmodule

bind lock_guard lock_guard_chk u_chk (
  .clk(clk), .por_n(por_n), .chip_erase(chip_erase), .prog_lb(prog_lb),
  .lock_bits(lock_bits), .grant_movc(grant_movc), .grant_prog(grant_prog),
  .grant_verify(grant_verify), .grant_ext(grant_ext), .ea_mismatch(ea_mismatch)
);

// File: tb/lock_guard_tb.sv
module lock_guard_tb;
  logic clk = 0;
  logic por_n, rst_n, chip_erase, ea_pin;
  logic [2:0] prog_lb;
  logic req_movc, req_prog, req_verify, req_ext_fetch;
  logic grant_movc, grant_prog, grant_verify, grant_ext, ea_mismatch;
  logic [2:0] lock_bits;

  int checks = 0, errors = 0;
  logic [2:0] m_lb;
  logic m_ea;
  bit done = 0;

  always #2 clk = ~clk;

  lock_guard u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .prog_lb(prog_lb),
    .chip_erase(chip_erase), .ea_pin(ea_pin), .req_movc(req_movc),
    .req_prog(req_prog), .req_verify(req_verify), .req_ext_fetch(req_ext_fetch),
    .grant_movc(grant_movc), .grant_prog(grant_prog), .grant_verify(grant_verify),
    .grant_ext(grant_ext), .ea_mismatch(ea_mismatch), .lock_bits(lock_bits)
  );

  function automatic logic f_mis(logic [2:0] lb, logic ea, logic pin, logic rn);
    return rn && (lb != 3'b000) && (ea != pin);
  endfunction

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic mis;
    mis = f_mis(m_lb, m_ea, ea_pin, rst_n);
    chk("R1/R2/R3 lock_bits", {1'b0, lock_bits}, {1'b0, m_lb});
    chk("R9 ea_mismatch", {3'b0, ea_mismatch}, {3'b0, mis});
    chk("R5 grant_movc", {3'b0, grant_movc}, {3'b0, req_movc && m_lb == 0 && !mis});
    chk("R5 grant_prog", {3'b0, grant_prog}, {3'b0, req_prog && m_lb == 0});
    chk("R6 grant_verify", {3'b0, grant_verify}, {3'b0, req_verify && !m_lb[1] && !m_lb[2]});
    chk("R7 grant_ext", {3'b0, grant_ext}, {3'b0, req_ext_fetch && !m_lb[2] && !mis});
  endtask

  // apply at negedge, check, then advance model at posedge
  task automatic step(logic p, logic r, logic [2:0] pl, logic er, logic ea, logic [3:0] rq);
    @(negedge clk);
    por_n = p; rst_n = r; prog_lb = pl; chip_erase = er; ea_pin = ea;
    {req_movc, req_prog, req_verify, req_ext_fetch} = rq;
    if (!p) begin m_lb = 0; m_ea = 0; end
    #1 check_all();
    @(posedge clk);
    if (p) begin
      m_lb = er ? 3'b000 : (m_lb | pl);
      if (!r) m_ea = ea;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    m_lb = 0; m_ea = 0;
    // R1 R10 reset state
    step(0, 0, 3'b111, 0, 1, 4'hF);
    chk("R1 lock_bits under por", {1'b0, lock_bits}, 4'h0);
    // R4 all granted when unlocked
    step(1, 1, 0, 0, 0, 4'hF);
    chk("R4 all grants", {grant_movc, grant_prog, grant_verify, grant_ext}, 4'hF);
    // R8 capture EA=1 during reset, program LB1
    step(1, 0, 3'b001, 0, 1, 4'h0);
    step(1, 1, 0, 0, 1, 4'hF);
    chk("R5 lb1 denies movc/prog", {grant_movc, grant_prog, grant_verify, grant_ext}, 4'b0011);
    // R9 pin drops outside reset
    step(1, 1, 0, 0, 0, 4'hF);
    chk("R9 mismatch masks fetch", {ea_mismatch, grant_ext, grant_movc, 1'b0}, 4'b1000);
    // R8 latch holds while rst_n high, R10: after por latch is 0
    step(0, 1, 0, 0, 0, 4'h0);
    step(1, 1, 3'b001, 0, 1, 4'hF);
    step(1, 1, 0, 0, 1, 4'hF);
    chk("R10 latch zero vs pin 1", {3'b0, ea_mismatch}, 4'h1);
    // R6 R7 escalate
    step(1, 0, 3'b110, 0, 1, 4'hF);
    step(1, 1, 0, 0, 1, 4'hF);
    chk("R7 full lock", {grant_movc, grant_prog, grant_verify, grant_ext}, 4'h0);
    // R3 erase beats program
    step(1, 1, 3'b111, 1, 1, 4'hF);
    step(1, 1, 0, 0, 1, 4'hF);
    chk("R3 erase wins", {1'b0, lock_bits}, 4'h0);
    for (int i = 0; i < 4000; i++) begin
      logic p, r, er, ea;
      logic [2:0] pl;
      p  = ($urandom % 200) != 0;
      r  = ($urandom % 8) != 0;
      er = ($urandom % 24) == 0;
      for (int b = 0; b < 3; b++) pl[b] = ($urandom % 10) == 0;
      ea = (($urandom % 6) == 0) ? ~ea_pin : ea_pin;
      step(p, r, pl, er, ea, 4'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule